// File: doc/BRIEF.md
# Channel Program Order Sequencer

This block runs a channel program held in memory. A program is a list of orders, each made of two 16-bit words: a control word followed by an address word. After a start pulse the sequencer fetches orders from a program counter, decodes the top bits of the control word and either acts inside the channel (jumps, bank selection, residue reporting) or issues a strobe to its single attached device (control, sense, interrupt, end, and word-by-word write and read transfers).

Memory and device each use a request/acknowledge handshake: a request is held, with stable address and data, until the matching acknowledge arrives, and the cycle with the acknowledge completes the access. Program fetches and status stores always address bank zero. Transfer addresses carry a bank register in their upper bits. An end order returns the block to idle. All other orders fall through to the next order pair.

Top module: `chan_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_req` and `dev_strobe` are low.
- R2: A `start` pulse in idle loads the program counter from `start_addr` and sets `busy`. The control word and then the address word are read from consecutive locations, with the upper address bits zero. The counter then points past the pair.
- R3: The order is picked from control-word bits 15..11. Bit 15 matters only for transfers. The device sees `dev_order` codes 0 control, 1 sense, 2 write, 3 read, 4 set-interrupt, 5 toggle-ok. Memory and device requests are never raised together.
- R4: Bits 15..11 = x0000 is an unconditional jump: the program counter takes the address word, and no strobe is issued.
- R5: x0001 is a conditional jump, taken only if `dev_jump` is high in the decode cycle. Otherwise the next pair follows.
- R6: x0011 sets the bank register from the low `BANK_W` bits of the address word without a strobe. The bank register forms the upper bits of every transfer address.
- R7: x0010 (return residue) writes the transfer count, sign-extended to 16 bits, into the location the address word was read from, without a strobe.
- R8: x010x (interrupt) issues one set-interrupt strobe and continues.
- R9: x0110 (end) issues toggle-ok and x0111 (end with interrupt) issues set-interrupt. The `dev_rdata` present at the acknowledge is stored into the address-word location, and the block then goes idle.
- R10: x1000 (control) strobes code 0 with the address word on `dev_wdata` and the control word on `dev_cw`. x1010 (sense) strobes code 1 and stores `dev_rdata` into the address-word location.
- R11: x1100 (write) takes a negative word count from bits 11..0. Each word is read from memory at {bank, buffer address} and strobed to the device. The address and count step by one, and the transfer ends when the count reaches zero. A zero count moves no words.
- R12: x1110 (read) strobes the device for each word and writes `dev_rdata` to memory at {bank, buffer address}.
- R13: For a transfer with bit 15 clear, `dev_last` accompanies the strobe of the final counted word. With bit 15 set (chained) it never rises. In both cases the next order is fetched directly afterwards.
- R14: A transfer-word acknowledge with `dev_stop` high ends the transfer after that word, and the remaining count is left for return residue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a program (idle only) |
| start_addr | input | 16 | First program word address |
| busy | output | 1 | Program running |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | BANK_W+16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 16 | Memory read data |
| dev_strobe | output | 1 | Device order request |
| dev_order | output | 3 | Device order code |
| dev_wdata | output | 16 | Data to device |
| dev_cw | output | 16 | Current control word |
| dev_last | output | 1 | Final word of unchained transfer |
| dev_ack | input | 1 | Device order complete |
| dev_rdata | input | 16 | Status or read data from device |
| dev_jump | input | 1 | Conditional-jump condition |
| dev_stop | input | 1 | Ends a transfer early |

## Verification
The bench builds the block with the default `BANK_W` of 4. This lets bank values 0, 2 and 3 land in distinct regions of its memory model and shows that the bank reaches the transfer addresses but not the program fetches. Zero-wait handshakes keep every order a few cycles long. This makes room for the full decode of all order patterns, including both interrupt encodings and the chained variants. It also leaves room for multi-word transfers with early stop and the residue read back through memory.

// File: rtl/chan_seq.sv
module chan_seq #(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       start_addr,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [BANK_W+15:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [15:0]       mem_rdata,
  output logic              dev_strobe,
  output logic [2:0]        dev_order,
  output logic [15:0]       dev_wdata,
  output logic [15:0]       dev_cw,
  output logic              dev_last,
  input  logic              dev_ack,
  input  logic [15:0]       dev_rdata,
  input  logic              dev_jump,
  input  logic              dev_stop
);
  localparam int CW = 12;

  typedef enum logic [2:0] {S_IDLE, S_FCW, S_FAW, S_EXEC, S_DEV, S_STORE, S_XMEM, S_XDEV} st_t;
  st_t st;

  logic [15:0] pc, aw, awloc, cw, xa, data;
  logic [BANK_W-1:0] bank;
  logic [CW-1:0] cnt;
  logic [2:0] ord;
  logic store_f, end_f, stop_f;

  wire rd      = cw[12];
  wire chain   = cw[15];
  wire [CW-1:0] cnt_n = cnt + 1'b1;
  wire last_w  = (cnt_n == '0);

  assign busy       = (st != S_IDLE);
  assign mem_req    = (st == S_FCW) || (st == S_FAW) || (st == S_STORE) || (st == S_XMEM);
  assign mem_we     = (st == S_STORE) || (st == S_XMEM && rd);
  assign mem_addr   = (st == S_XMEM) ? {bank, xa} :
                      (st == S_STORE) ? {{BANK_W{1'b0}}, awloc} : {{BANK_W{1'b0}}, pc};
  assign mem_wdata  = data;
  assign dev_strobe = (st == S_DEV) || (st == S_XDEV);
  assign dev_order  = ord;
  assign dev_wdata  = (st == S_XDEV) ? data : aw;
  assign dev_cw     = cw;
  assign dev_last   = (st == S_XDEV) && !chain && last_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pc <= '0; aw <= '0; awloc <= '0; cw <= '0; xa <= '0;
      data <= '0; bank <= '0; cnt <= '0; ord <= '0;
      store_f <= 1'b0; end_f <= 1'b0; stop_f <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin pc <= start_addr; st <= S_FCW; end
        S_FCW: if (mem_ack) begin cw <= mem_rdata; pc <= pc + 16'd1; st <= S_FAW; end
        S_FAW: if (mem_ack) begin aw <= mem_rdata; awloc <= pc; pc <= pc + 16'd1; st <= S_EXEC; end
        S_EXEC: begin
          store_f <= 1'b0; end_f <= 1'b0; stop_f <= 1'b0;
          st <= S_FCW;
          if (cw[14]) begin
            if (!cw[13]) begin
              ord <= cw[12] ? 3'd1 : 3'd0;
              store_f <= cw[12];
              st <= S_DEV;
            end else begin
              ord <= cw[12] ? 3'd3 : 3'd2;
              cnt <= cw[CW-1:0];
              xa <= aw;
              if (cw[CW-1:0] != '0) st <= cw[12] ? S_XDEV : S_XMEM;
            end
          end else if (!cw[13]) begin
            case (cw[12:11])
              2'b00: pc <= aw;
              2'b01: if (dev_jump) pc <= aw;
              2'b10: begin data <= {{(16-CW){cnt[CW-1]}}, cnt}; st <= S_STORE; end
              default: bank <= aw[BANK_W-1:0];
            endcase
          end else begin
            st <= S_DEV;
            if (!cw[12]) ord <= 3'd4;
            else begin
              ord <= cw[11] ? 3'd4 : 3'd5;
              store_f <= 1'b1;
              end_f <= 1'b1;
            end
          end
        end
        S_DEV: if (dev_ack) begin
          if (store_f) begin data <= dev_rdata; st <= S_STORE; end
          else st <= S_FCW;
        end
        S_STORE: if (mem_ack) st <= end_f ? S_IDLE : S_FCW;
        S_XMEM: if (mem_ack) begin
          if (!rd) begin data <= mem_rdata; st <= S_XDEV; end
          else begin
            xa <= xa + 16'd1; cnt <= cnt_n;
            st <= (last_w || stop_f) ? S_FCW : S_XDEV;
          end
        end
        S_XDEV: if (dev_ack) begin
          if (rd) begin data <= dev_rdata; stop_f <= dev_stop; st <= S_XMEM; end
          else begin
            xa <= xa + 16'd1; cnt <= cnt_n;
            st <= (last_w || dev_stop) ? S_FCW : S_XMEM;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chan_seq_chk.sv
module chan_seq_chk #(
  parameter int BANK_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [BANK_W+15:0] mem_addr,
  input logic              dev_strobe,
  input logic              dev_ack,
  input logic [2:0]        dev_order,
  input logic              dev_last
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !dev_strobe));
  a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  a_r3_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && dev_strobe));
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  a_r9_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_strobe && !dev_ack) |=> (dev_strobe && $stable(dev_order)));
  a_r13_last_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    dev_last |-> (dev_strobe && (dev_order == 3'd2 || dev_order == 3'd3)));
endmodule

bind chan_seq chan_seq_chk #(.BANK_W(BANK_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .dev_strobe(dev_strobe), .dev_ack(dev_ack),
  .dev_order(dev_order), .dev_last(dev_last)
);

// File: tb/test_chan_seq.sv
module test_chan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] start_addr = '0;
  logic busy, mem_req, mem_we, dev_strobe, dev_last;
  logic [BW+15:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, dev_wdata, dev_cw, dev_rdata;
  logic [2:0] dev_order;
  logic dev_jump = 1'b0;
  int stop_at = -1;

  logic [15:0] mem [0:4095];
  logic [2:0]  lg_ord  [0:31];
  logic [15:0] lg_data [0:31];
  logic [15:0] lg_cw   [0:31];
  logic        lg_last [0:31];
  int lcnt = 0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int idx(input logic [BW+15:0] a);
    return {a[BW+15:16], a[7:0]};
  endfunction

  assign mem_rdata = mem[idx(mem_addr)];
  assign dev_rdata = 16'hA500 | 16'(lcnt);
  wire dev_stop = (stop_at == lcnt);

  chan_seq #(.BANK_W(BW)) i_chan_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_req), .mem_rdata(mem_rdata), .dev_strobe(dev_strobe), .dev_order(dev_order),
    .dev_wdata(dev_wdata), .dev_cw(dev_cw), .dev_last(dev_last), .dev_ack(dev_strobe),
    .dev_rdata(dev_rdata), .dev_jump(dev_jump), .dev_stop(dev_stop)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[idx(mem_addr)] <= mem_wdata;
    if (dev_strobe && lcnt < 32) begin
      lg_ord[lcnt] <= dev_order; lg_data[lcnt] <= dev_wdata;
      lg_cw[lcnt] <= dev_cw; lg_last[lcnt] <= dev_last;
      lcnt <= lcnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
  endtask

  task automatic run(input logic [15:0] a);
    int t;
    @(negedge clk);
    lcnt = 0;
    start_addr = a; start = 1'b1;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (busy && t < 2000) begin @(negedge clk); t++; end
    chk("R9 program ends idle", 32'(busy), 32'd0);
  endtask

  // {cw, aw, first order, strobe count}
  localparam logic [38:0] TBL [11] = '{
    {16'h4123, 16'h0080, 3'd0, 4'd2},
    {16'h5000, 16'h0080, 3'd1, 4'd2},
    {16'h2000, 16'h0080, 3'd4, 4'd2},
    {16'h2800, 16'h0080, 3'd4, 4'd2},
    {16'h6FFE, 16'h0080, 3'd2, 4'd3},
    {16'h7FFF, 16'h0080, 3'd3, 4'd2},
    {16'hEFFF, 16'h0080, 3'd2, 4'd2},
    {16'h1000, 16'h0080, 3'd5, 4'd1},
    {16'h1800, 16'h0000, 3'd5, 4'd1},
    {16'h3000, 16'h0080, 3'd5, 4'd1},
    {16'h3800, 16'h0080, 3'd4, 4'd1}
  };

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 dev_strobe", 32'(dev_strobe), 0);
        rst_n = 1'b1;

        // R3 R8 decode table
        for (int v = 0; v < 11; v++) begin
          clr();
          mem[0] = TBL[v][38:23]; mem[1] = TBL[v][22:7];
          mem[2] = 16'h3000; mem[3] = 16'h0000;
          run(16'h0000);
          chk("R3 first order", 32'(lg_ord[0]), 32'(TBL[v][6:4]));
          chk("R3 R8 strobe count", 32'(lcnt), 32'(TBL[v][3:0]));
        end

        // R4 R2 jump
        clr();
        mem[16] = 16'h0000; mem[17] = 16'h0020; mem[32] = 16'h3000;
        run(16'h0010);
        chk("R4 strobes", 32'(lcnt), 1);
        chk("R4 order", 32'(lg_ord[0]), 5);
        chk("R9 end status stored", 32'(mem[33]), 32'h0000A500);

        // R5 conditional jump taken / not taken
        for (int j = 0; j < 2; j++) begin
          clr();
          mem[16] = 16'h0800; mem[17] = 16'h0030; mem[18] = 16'h3800; mem[48] = 16'h3000;
          dev_jump = j[0];
          run(16'h0010);
          chk("R5 order", 32'(lg_ord[0]), j ? 5 : 4);
          chk("R5 status location", 32'(j ? mem[49] : mem[19]), 32'h0000A500);
        end
        dev_jump = 1'b0;

        // R10 control and sense
        clr();
        mem[16] = 16'h4ABC; mem[17] = 16'h1234; mem[18] = 16'h5000; mem[19] = 16'h0040;
        mem[20] = 16'h3000;
        run(16'h0010);
        chk("R10 control order", 32'(lg_ord[0]), 0);
        chk("R10 control aw", 32'(lg_data[0]), 32'h1234);
        chk("R10 control cw", 32'(lg_cw[0]), 32'h4ABC);
        chk("R10 sense stored", 32'(mem[19]), 32'hA501);
        chk("R9 end status", 32'(mem[21]), 32'hA502);

        // R6 R11 R13 bank + unchained write of 3
        clr();
        mem[16] = 16'h1800; mem[17] = 16'h0002; mem[18] = 16'h6FFD; mem[19] = 16'h0040;
        mem[20] = 16'h3000;
        mem[12'h240] = 16'h1111; mem[12'h241] = 16'h2222; mem[12'h242] = 16'h3333;
        run(16'h0010);
        chk("R11 strobes", 32'(lcnt), 4);
        for (int k = 0; k < 3; k++) begin
          chk("R6 R11 write data", 32'(lg_data[k]), 32'h1111 * (k + 1));
          chk("R13 last flag", 32'(lg_last[k]), k == 2 ? 1 : 0);
        end
        chk("R2 fetch after bank", 32'(lg_ord[3]), 5);

        // R12 R13 chained read of 2 in bank 3
        clr();
        mem[16] = 16'h1800; mem[17] = 16'h0003; mem[18] = 16'hFFFE; mem[19] = 16'h0050;
        mem[20] = 16'h3000;
        run(16'h0010);
        chk("R12 word0", 32'(mem[12'h350]), 32'hA500);
        chk("R12 word1", 32'(mem[12'h351]), 32'hA501);
        chk("R13 chained no last", 32'(lg_last[0] | lg_last[1]), 0);
        chk("R13 next order", 32'(lg_ord[2]), 5);

        // R14 R7 early stop and residue
        clr();
        mem[16] = 16'h1800; mem[17] = 16'h0000; mem[18] = 16'h6FFC; mem[19] = 16'h0060;
        mem[20] = 16'h1000; mem[21] = 16'h0099; mem[22] = 16'h3000;
        stop_at = 1;
        run(16'h0010);
        stop_at = -1;
        chk("R14 strobes", 32'(lcnt), 3);
        chk("R7 residue", 32'(mem[21]), 32'hFFFE);

        // R11 zero count
        clr();
        mem[16] = 16'h6000; mem[17] = 16'h0060; mem[18] = 16'h3000;
        run(16'h0010);
        chk("R11 zero count strobes", 32'(lcnt), 1);
        chk("R11 zero count order", 32'(lg_ord[0]), 5);
      end
      begin
        while (wd < 150000) begin @(posedge clk); wd++; end
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=done", wd);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule